// File: doc/BRIEF.md
# Type B Tag Frame Encoder

This block turns a run of bytes into the oversampled serial line that drives a proximity-card subcarrier modulator on the tag side. The upstream logic supplies the bytes with their CRC already appended. The block does not compute or check a CRC; the bytes go out exactly as they were handed over. Every elementary time unit (etu) is held on the output for `OVS` consecutive samples. A sample is produced only on a clock cycle in which `sample_en` is high.

A frame starts when `start_i` is pulsed while the block is idle. The block first latches `frame_len_i`. It then sends:

- an all-ones run so the reader can lock its phase reference;
- a start-of-frame mark;
- one asynchronous character per byte;
- an end-of-frame mark.

Bytes are pulled through a valid/ready handshake. Each byte is fetched while the character before it is still on the line, so a source that keeps `byte_valid_i` high produces characters back to back. `busy_o` covers the whole frame. `done_o` marks its end.

Top module: `tagb_frame_enc`

## Requirements
- R1: After reset `tx_bit_o` is 1, `busy_o` is 0, `done_o` is 0 and `byte_ready_o` is 0. The line rests at 1 whenever the block is idle.
- R2: Every etu is exactly OVS (default 4) consecutive output samples. A frame of N bytes with no source stall is 176 + 40·N samples long.
- R3: A frame opens with 20 etu (80 samples) of logic 1.
- R4: After the opening run, the start-of-frame mark is 10 etu of 0 followed by 2 etu of 1.
- R5: Each byte is sent as one character of 10 etu. The character is a 0 start etu, then the eight data bits least-significant first, then a 1 stop etu. The next start etu follows the stop etu directly.
- R6: After the last character, the end-of-frame mark is 10 etu of 0 followed by 2 etu of 1. The line then stays at 1.
- R7: The block accepts exactly `frame_len_i` bytes, and the bytes are sent unchanged. `byte_ready_o` is high only inside two windows:
  - for the first byte, during the 2-etu high part of the start-of-frame mark;
  - for each later byte, from the start of the current character's last data-bit etu until the byte is taken.
- R8: If no byte has been taken by the end of its window, the line is held at 1 for whole extra etus until a byte arrives. That character then starts on the next etu boundary.
- R9: `busy_o` rises on the clock edge that takes the start strobe. It falls on the edge that drives the last sample of the end-of-frame mark. `done_o` is high for exactly that one following cycle.
- R10: A start strobe that arrives while `busy_o` is high is ignored. The running frame, its length and its byte count are not affected.
- R11: A frame length of 0 produces the opening run, the start-of-frame mark and the end-of-frame mark with no characters. No byte is requested.
- R12: In a cycle where `sample_en` is low, the frame does not advance and `tx_bit_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_en | input | 1 | Sample-rate enable; one output sample per high cycle |
| start_i | input | 1 | Frame start strobe, taken only when idle |
| frame_len_i | input | LEN_W | Number of bytes in the frame, CRC included |
| byte_data_i | input | 8 | Byte offered by the source |
| byte_valid_i | input | 1 | Source has a byte on `byte_data_i` |
| byte_ready_o | output | 1 | Encoder takes the byte in this cycle if valid |
| tx_bit_o | output | 1 | Registered line sample for the modulator |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse after the final sample |

## Verification
The bench targets these corner cases:

- **Segment boundaries.** A length error of one etu in the opening run or in either mark shifts every later sample, so the segment-by-segment stream compare catches it.
- **Byte pre-fetch timing.** If the next byte is taken too late, even a source that is always ready leaves a gap of ones between characters. If the ready window is too wide, `byte_ready_o` is seen outside the stated windows.
- **Source stall.** When a byte is withheld past its window, a design that neither pads with ones nor bypasses the holding register either drops the byte or emits a gap that is not a whole number of etus.
- **Stray start strobes.** A frame restarted or resized by a strobe during `busy_o` shows up as a wrong byte count or a second `done_o` pulse.
- **Edge cases of length and enable.** Zero-length frames and a gated `sample_en` are exercised, so a design that advances without an enable, or requests a byte for an empty frame, fails.

// File: rtl/tagb_enc_pkg.sv
package tagb_enc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_SOF_LO,
    ST_SOF_HI,
    ST_FILL,
    ST_CHAR,
    ST_EOF_LO,
    ST_EOF_HI
  } tagb_state_e;

  // character layout, in etu: start, 8 data, stop
  localparam int unsigned CHAR_ETU      = 10;
  localparam int unsigned STOP_IDX      = CHAR_ETU - 1;
  localparam int unsigned LAST_DATA_IDX = CHAR_ETU - 2;

  function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/tagb_etu_timer.sv
module tagb_etu_timer #(
  parameter int unsigned OVS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  input  logic sample_en,
  output logic etu_end
);

  localparam int unsigned SUB_W = (OVS > 1) ? $clog2(OVS) : 1;

  generate
    if (OVS > 1) begin : g_div
      logic [SUB_W-1:0] sub_q;

      always_ff @(posedge clk) begin
        if (rst || clear) begin
          sub_q <= '0;
        end else if (run && sample_en) begin
          if (sub_q == SUB_W'(OVS - 1)) sub_q <= '0;
          else                          sub_q <= sub_q + SUB_W'(1);
        end
      end

      assign etu_end = run && sample_en && (sub_q == SUB_W'(OVS - 1));
    end else begin : g_pass
      assign etu_end = run && sample_en;
    end
  endgenerate

endmodule

// File: rtl/tagb_byte_stage.sv
module tagb_byte_stage #(
  parameter int unsigned LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic [LEN_W-1:0] frame_len,
  input  logic             window,
  input  logic             take,
  input  logic [7:0]       src_data,
  input  logic             src_valid,
  output logic             src_ready,
  output logic             have_next,
  output logic [7:0]       next_byte,
  output logic             more
);

  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] fetched_q;
  logic [7:0]       hold_q;
  logic             have_q;
  logic             cap;

  assign src_ready = window && !have_q && (fetched_q != len_q);
  assign cap       = src_valid && src_ready;
  assign have_next = have_q || cap;
  assign next_byte = have_q ? hold_q : src_data;
  assign more      = have_q || (fetched_q != len_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q     <= '0;
      fetched_q <= '0;
      have_q    <= 1'b0;
      hold_q    <= '0;
    end else if (clear) begin
      len_q     <= frame_len;
      fetched_q <= '0;
      have_q    <= 1'b0;
    end else begin
      if (cap) fetched_q <= fetched_q + LEN_W'(1);
      if (take) begin
        have_q <= 1'b0;
      end else if (cap) begin
        have_q <= 1'b1;
        hold_q <= src_data;
      end
    end
  end

endmodule

// File: rtl/tagb_frame_seq.sv
module tagb_frame_seq
  import tagb_enc_pkg::*;
#(
  parameter int unsigned PRE_ETU    = 20,
  parameter int unsigned SOF_LO_ETU = 10,
  parameter int unsigned SOF_HI_ETU = 2,
  parameter int unsigned EOF_LO_ETU = 10,
  parameter int unsigned EOF_HI_ETU = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_acc,
  input  logic       etu_end,
  input  logic       have_next,
  input  logic [7:0] next_byte,
  input  logic       more,
  output logic       active,
  output logic       bit_val,
  output logic       window,
  output logic       take,
  output logic       frame_end
);

  localparam int unsigned MAX_PH = max_of(max_of(max_of(PRE_ETU, SOF_LO_ETU),
                                                 max_of(SOF_HI_ETU, EOF_LO_ETU)),
                                          max_of(EOF_HI_ETU, CHAR_ETU));
  localparam int unsigned ETU_W  = $clog2(MAX_PH + 1);

  tagb_state_e      state_q, state_d;
  logic [ETU_W-1:0] etu_q;
  logic [ETU_W-1:0] last_idx;
  logic [ETU_W-1:0] dsel_full;
  logic [2:0]       data_sel;
  logic [7:0]       cur_q;
  logic             last_etu;
  logic             phase_done;

  always_comb begin
    unique case (state_q)
      ST_PRE:    last_idx = ETU_W'(PRE_ETU - 1);
      ST_SOF_LO: last_idx = ETU_W'(SOF_LO_ETU - 1);
      ST_SOF_HI: last_idx = ETU_W'(SOF_HI_ETU - 1);
      ST_CHAR:   last_idx = ETU_W'(CHAR_ETU - 1);
      ST_EOF_LO: last_idx = ETU_W'(EOF_LO_ETU - 1);
      ST_EOF_HI: last_idx = ETU_W'(EOF_HI_ETU - 1);
      default:   last_idx = '0;
    endcase
  end

  assign last_etu   = (etu_q == last_idx);
  assign phase_done = etu_end && last_etu;
  assign active     = (state_q != ST_IDLE);
  assign frame_end  = phase_done && (state_q == ST_EOF_HI);

  // A character may follow the high part of SOF, a filler etu or a stop etu.
  logic at_char_gate;
  assign at_char_gate = (state_q == ST_SOF_HI) || (state_q == ST_FILL) || (state_q == ST_CHAR);

  always_comb begin
    state_d = state_q;
    take    = 1'b0;
    if (phase_done) begin
      unique case (state_q)
        ST_PRE:    state_d = ST_SOF_LO;
        ST_SOF_LO: state_d = ST_SOF_HI;
        ST_EOF_LO: state_d = ST_EOF_HI;
        ST_EOF_HI: state_d = ST_IDLE;
        default: begin
          if (at_char_gate) begin
            if (!more) begin
              state_d = ST_EOF_LO;
            end else if (have_next) begin
              state_d = ST_CHAR;
              take    = 1'b1;
            end else begin
              state_d = ST_FILL;
            end
          end
        end
      endcase
    end
  end

  assign window = (state_q == ST_SOF_HI) || (state_q == ST_FILL) ||
                  ((state_q == ST_CHAR) && (etu_q >= ETU_W'(LAST_DATA_IDX)));

  assign dsel_full = etu_q - ETU_W'(1);
  assign data_sel  = dsel_full[2:0];

  always_comb begin
    unique case (state_q)
      ST_SOF_LO, ST_EOF_LO: bit_val = 1'b0;
      ST_CHAR: begin
        if (etu_q == '0)                        bit_val = 1'b0;
        else if (etu_q == ETU_W'(STOP_IDX))     bit_val = 1'b1;
        else                                    bit_val = cur_q[data_sel];
      end
      default: bit_val = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      etu_q   <= '0;
      cur_q   <= '0;
    end else if (start_acc) begin
      state_q <= ST_PRE;
      etu_q   <= '0;
    end else begin
      state_q <= state_d;
      if (phase_done)   etu_q <= '0;
      else if (etu_end) etu_q <= etu_q + ETU_W'(1);
      if (take) cur_q <= next_byte;
    end
  end

endmodule

// File: rtl/tagb_frame_enc.sv
module tagb_frame_enc #(
  parameter int unsigned LEN_W      = 8,
  parameter int unsigned OVS        = 4,
  parameter int unsigned PRE_ETU    = 20,
  parameter int unsigned SOF_LO_ETU = 10,
  parameter int unsigned SOF_HI_ETU = 2,
  parameter int unsigned EOF_LO_ETU = 10,
  parameter int unsigned EOF_HI_ETU = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sample_en,
  input  logic             start_i,
  input  logic [LEN_W-1:0] frame_len_i,
  input  logic [7:0]       byte_data_i,
  input  logic             byte_valid_i,
  output logic             byte_ready_o,
  output logic             tx_bit_o,
  output logic             busy_o,
  output logic             done_o
);

  logic       busy_q, done_q, tx_q;
  logic       start_acc;
  logic       etu_end;
  logic       active;
  logic       bit_val;
  logic       window;
  logic       take;
  logic       frame_end;
  logic       have_next;
  logic       more;
  logic [7:0] next_byte;

  assign start_acc = start_i && !busy_q;

  tagb_etu_timer #(.OVS(OVS)) timer_i (
    .clk       (clk),
    .rst       (rst),
    .clear     (start_acc),
    .run       (active),
    .sample_en (sample_en),
    .etu_end   (etu_end)
  );

  tagb_byte_stage #(.LEN_W(LEN_W)) stage_i (
    .clk       (clk),
    .rst       (rst),
    .clear     (start_acc),
    .frame_len (frame_len_i),
    .window    (window),
    .take      (take),
    .src_data  (byte_data_i),
    .src_valid (byte_valid_i),
    .src_ready (byte_ready_o),
    .have_next (have_next),
    .next_byte (next_byte),
    .more      (more)
  );

  tagb_frame_seq #(
    .PRE_ETU    (PRE_ETU),
    .SOF_LO_ETU (SOF_LO_ETU),
    .SOF_HI_ETU (SOF_HI_ETU),
    .EOF_LO_ETU (EOF_LO_ETU),
    .EOF_HI_ETU (EOF_HI_ETU)
  ) seq_i (
    .clk       (clk),
    .rst       (rst),
    .start_acc (start_acc),
    .etu_end   (etu_end),
    .have_next (have_next),
    .next_byte (next_byte),
    .more      (more),
    .active    (active),
    .bit_val   (bit_val),
    .window    (window),
    .take      (take),
    .frame_end (frame_end)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q   <= 1'b1;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (sample_en && active) tx_q <= bit_val;
      if (start_acc)      busy_q <= 1'b1;
      else if (frame_end) busy_q <= 1'b0;
      done_q <= frame_end;
    end
  end

  assign tx_bit_o = tx_q;
  assign busy_o   = busy_q;
  assign done_o   = done_q;

endmodule

// File: rtl/tagb_enc_chk.sv
module tagb_enc_chk #(
  parameter int unsigned LEN_W = 8,
  parameter int unsigned OVS   = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             sample_en,
  input logic             start_i,
  input logic [LEN_W-1:0] frame_len_i,
  input logic             byte_valid_i,
  input logic             byte_ready_o,
  input logic             tx_bit_o,
  input logic             busy_o,
  input logic             done_o
);

  localparam int unsigned MOD_W = (OVS > 1) ? $clog2(OVS) : 1;

  logic [MOD_W-1:0] samp_mod;
  logic [LEN_W-1:0] len_lat;
  logic [LEN_W:0]   hs_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      samp_mod <= '0;
      len_lat  <= '0;
      hs_cnt   <= '0;
    end else if (start_i && !busy_o) begin
      samp_mod <= '0;
      len_lat  <= frame_len_i;
      hs_cnt   <= '0;
    end else begin
      if (busy_o && sample_en) begin
        if (samp_mod == MOD_W'(OVS - 1)) samp_mod <= '0;
        else                             samp_mod <= samp_mod + MOD_W'(1);
      end
      if (byte_valid_i && byte_ready_o) hs_cnt <= hs_cnt + (LEN_W+1)'(1);
    end
  end

  // R2: inside an etu the line value does not change
  a_r2_etu_hold: assert property (@(posedge clk) disable iff (rst)
    (busy_o && sample_en && samp_mod != '0) |=> $stable(tx_bit_o));

  // R12: no enable, no change
  a_r12_no_enable_hold: assert property (@(posedge clk) disable iff (rst)
    !sample_en |=> $stable(tx_bit_o));

  // R1: line rests high while idle
  a_r1_idle_high: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> tx_bit_o);

  // R7: byte requests only inside a frame
  a_r7_ready_in_frame: assert property (@(posedge clk) disable iff (rst)
    byte_ready_o |-> busy_o);

  // R7 / R10: byte count matches the length latched at the accepted start
  a_r7_byte_count: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (hs_cnt == {1'b0, len_lat}));

  // R9: done is a single-cycle pulse
  a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R9: busy ends only together with done
  a_r9_busy_end: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> done_o);

  a_r9_done_after_busy: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && $past(busy_o)));

endmodule

bind tagb_frame_enc tagb_enc_chk #(.LEN_W(LEN_W), .OVS(OVS)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .sample_en    (sample_en),
  .start_i      (start_i),
  .frame_len_i  (frame_len_i),
  .byte_valid_i (byte_valid_i),
  .byte_ready_o (byte_ready_o),
  .tx_bit_o     (tx_bit_o),
  .busy_o       (busy_o),
  .done_o       (done_o)
);

// File: tb/tagb_frame_enc_tb_top.sv
module tagb_frame_enc_tb_top;

  localparam int LEN_W = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             sample_en = 1'b0;
  logic             start_i = 1'b0;
  logic [LEN_W-1:0] frame_len_i = '0;
  logic [7:0]       byte_data_i = '0;
  logic             byte_valid_i = 1'b0;
  logic             byte_ready_o;
  logic             tx_bit_o;
  logic             busy_o;
  logic             done_o;

  tagb_frame_enc #(.LEN_W(LEN_W)) dut_i (
    .clk          (clk),
    .rst          (rst),
    .sample_en    (sample_en),
    .start_i      (start_i),
    .frame_len_i  (frame_len_i),
    .byte_data_i  (byte_data_i),
    .byte_valid_i (byte_valid_i),
    .byte_ready_o (byte_ready_o),
    .tx_bit_o     (tx_bit_o),
    .busy_o       (busy_o),
    .done_o       (done_o)
  );

  always #5 clk = ~clk;

  int   errors = 0;
  int   checks = 0;
  logic stream [0:2047];
  logic expb   [0:2047];
  int   scount = 0;
  int   ecount = 0;
  logic [7:0] src [0:15];
  int   src_n = 0, src_idx = 0, hs_cnt = 0;
  int   en_div = 1, hold_idx = -1, rel_count = 0;
  int   cyc = 0, busy_cnt = 0, done_cnt = 0, done_at = -1;
  int   rdy_bad = 0, nonen_change = 0;
  bit   win_check = 1'b1;
  logic en_d = 1'b0, busy_d = 1'b0, vld_d = 1'b0, rdy_d = 1'b0, tx_prev = 1'b1;

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit in_window(input int p);
    if (p >= 120 && p < 128) return 1'b1;
    if (p >= 128 && ((p - 128) % 40) >= 32) return 1'b1;
    return 1'b0;
  endfunction

  // monitor and stimulus driver, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (en_d && busy_d) begin
        stream[scount] = tx_bit_o;
        scount++;
      end else if (tx_bit_o !== tx_prev) begin
        nonen_change++;
      end
      if (vld_d && rdy_d) begin
        src_idx++;
        hs_cnt++;
      end
      if (busy_o) busy_cnt++;
      if (done_o) begin
        done_cnt++;
        done_at = scount;
      end
      if (win_check && byte_ready_o && !in_window(scount)) rdy_bad++;
    end
    tx_prev      = tx_bit_o;
    sample_en    = (en_div <= 1) ? 1'b1 : ((cyc % en_div) == 0);
    byte_valid_i = (src_idx < src_n) && !(src_idx == hold_idx && scount < rel_count);
    byte_data_i  = (src_idx < src_n && src_idx < 16) ? src[src_idx] : 8'h00;
    en_d   = sample_en;
    busy_d = busy_o;
    vld_d  = byte_valid_i;
    rdy_d  = byte_ready_o;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
      summary();
      $finish;
    end
  end

  task automatic build_exp(input int n, input int fill0);
    int k = 0;
    for (int i = 0; i < 80; i++) begin expb[k] = 1'b1; k++; end
    for (int i = 0; i < 40; i++) begin expb[k] = 1'b0; k++; end
    for (int i = 0; i < 8;  i++) begin expb[k] = 1'b1; k++; end
    for (int c = 0; c < n; c++) begin
      for (int i = 0; i < 4; i++) begin expb[k] = 1'b0; k++; end
      for (int b = 0; b < 8; b++)
        for (int i = 0; i < 4; i++) begin expb[k] = src[c][b]; k++; end
      for (int i = 0; i < 4; i++) begin expb[k] = 1'b1; k++; end
      if (c == 0)
        for (int i = 0; i < 4 * fill0; i++) begin expb[k] = 1'b1; k++; end
    end
    for (int i = 0; i < 40; i++) begin expb[k] = 1'b0; k++; end
    for (int i = 0; i < 8;  i++) begin expb[k] = 1'b1; k++; end
    ecount = k;
  endtask

  task automatic cmp_range(input int lo, input int hi, input string req, input string what);
    int mism = 0;
    for (int i = lo; i < hi; i++)
      if (stream[i] !== expb[i]) mism++;
    check(mism == 0, req, what, mism, 0);
  endtask

  task automatic run_frame(input int n, input int div, input int hold,
                           input int rel, input bit spam);
    @(posedge clk); #2;
    src_n = n; src_idx = 0; hs_cnt = 0; scount = 0; busy_cnt = 0;
    done_cnt = 0; done_at = -1; rdy_bad = 0; nonen_change = 0;
    en_div = div; hold_idx = hold; rel_count = rel;
    for (int i = 0; i < 2048; i++) stream[i] = 1'bx;
    frame_len_i = LEN_W'(n);
    start_i = 1'b1;
    @(posedge clk); #2;
    start_i = 1'b0;
    if (spam) begin
      repeat (200) @(posedge clk);
      #2;
      start_i = 1'b1;
      frame_len_i = 8'd5;
      @(posedge clk); #2;
      start_i = 1'b0;
    end
    for (int t = 0; t < 20000 && done_cnt == 0; t++) @(posedge clk);
    repeat (6) @(posedge clk);
  endtask

  task automatic frame_checks(input int n, input int fill0, input int div);
    build_exp(n, fill0);
    check(scount == ecount, "R2", "sample count of frame", scount, ecount);
    cmp_range(0, 80, "R3", "opening ones run");
    cmp_range(80, 128, "R4", "start-of-frame mark");
    cmp_range(128, ecount - 48, "R5", "character stream");
    cmp_range(ecount - 48, ecount, "R6", "end-of-frame mark");
    check(hs_cnt == n, "R7", "bytes accepted", hs_cnt, n);
    check(done_cnt == 1, "R9", "done pulses", done_cnt, 1);
    check(done_at == ecount, "R9", "done right after last sample", done_at, ecount);
    check(busy_o == 1'b0, "R9", "busy low after frame", int'(busy_o), 0);
    check(tx_bit_o == 1'b1, "R6", "line high after frame", int'(tx_bit_o), 1);
    if (div == 1) check(busy_cnt == ecount, "R9", "busy length in cycles", busy_cnt, ecount);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (5) @(posedge clk);
    #2 rst = 1'b0;
    @(posedge clk); #2;
    check(tx_bit_o == 1'b1, "R1", "tx after reset", int'(tx_bit_o), 1);
    check(busy_o == 1'b0, "R1", "busy after reset", int'(busy_o), 0);
    check(done_o == 1'b0, "R1", "done after reset", int'(done_o), 0);
    check(byte_ready_o == 1'b0, "R1", "ready after reset", int'(byte_ready_o), 0);
  endtask

  task automatic t_basic_frame();
    src[0] = 8'hA5; src[1] = 8'h3C; src[2] = 8'h00; src[3] = 8'hFF;
    win_check = 1'b1;
    run_frame(4, 1, -1, 0, 1'b0);
    frame_checks(4, 0, 1);
    check(rdy_bad == 0, "R7", "ready outside window", rdy_bad, 0);
  endtask

  task automatic t_gapped_enable();
    src[0] = 8'h80; src[1] = 8'h7E;
    win_check = 1'b1;
    run_frame(2, 3, -1, 0, 1'b0);
    frame_checks(2, 0, 3);
    check(nonen_change == 0, "R12", "line moved without enable", nonen_change, 0);
    check(rdy_bad == 0, "R7", "ready outside window (gapped)", rdy_bad, 0);
  endtask

  task automatic t_empty_frame();
    win_check = 1'b1;
    run_frame(0, 1, -1, 0, 1'b0);
    frame_checks(0, 0, 1);
    check(rdy_bad == 0, "R11", "ready during empty frame", rdy_bad, 0);
    check(scount == 176, "R11", "empty frame length", scount, 176);
  endtask

  task automatic t_underrun();
    src[0] = 8'hC3; src[1] = 8'h5A;
    win_check = 1'b0;
    run_frame(2, 1, 1, 174, 1'b0);
    frame_checks(2, 2, 1);
    check(scount == 264, "R8", "stalled frame padded by two etus", scount, 264);
    win_check = 1'b1;
  endtask

  task automatic t_start_while_busy();
    src[0] = 8'h0F; src[1] = 8'hF0;
    win_check = 1'b1;
    run_frame(2, 1, -1, 0, 1'b1);
    frame_checks(2, 0, 1);
    check(hs_cnt == 2, "R10", "stray start left byte count", hs_cnt, 2);
    check(done_cnt == 1, "R10", "stray start caused no second frame", done_cnt, 1);
  endtask

  initial begin
    t_reset();
    t_basic_frame();
    t_gapped_enable();
    t_empty_frame();
    t_underrun();
    t_start_while_busy();
    summary();
    $finish;
  end

endmodule